// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the multiply and accumulate execution path of a fixed-point signal processor. It holds a 16-bit multiplicand register `x`, a 32-bit register `y`, a 32-bit product register `p` and a bank of two 36-bit accumulators. The signed multiplier takes `x` and the upper half of `y` and writes their product into `p`. The accumulate unit can move `p` into an accumulator, add `p` to an accumulator, subtract `p` from an accumulator, or move `y` into an accumulator. Before it reaches the accumulate unit, `p` is sign-extended to 36 bits and passed through a shifter with four settings.

Each cycle the upstream decoder sends an accumulate operation code, a multiply enable, source and destination accumulator indices, and optional loads of `x` and `y`. A multiply and an accumulate operation can run in the same cycle. In that case the accumulate unit reads the product from before the edge, and the new product lands in `p` at the same edge. When squaring mode is on, a load of `y` also copies its upper half into `x`. The next multiply then yields the square of that value.

Top module: `fmac_datapath`

## Requirements
- R1: While `rst_n` is low, `x_q`, `y_q`, `p_q`, `acc0_q` and `acc1_q` read zero.
- R2: With `mul_en` high, at the next rising edge `p_q` becomes the signed 32-bit product of `x_q` and `y_q[31:16]` as held before that edge. `y_q[15:0]` has no effect on it. With `mul_en` low, `p_q` holds.
- R3: With `mul_en` high and `alu_op` = 0 (none), both accumulators keep their values.
- R4: `alu_op` = 1 writes the aligned `p_q` into the accumulator selected by `acc_dst` (0 = acc0, 1 = acc1).
- R5: `alu_op` = 2 writes (accumulator `acc_src`) + aligned `p_q` into accumulator `acc_dst`. The sum wraps modulo 2^36.
- R6: `alu_op` = 3 writes (accumulator `acc_src`) − aligned `p_q` into accumulator `acc_dst`. The operand order is never reversed, and the difference wraps modulo 2^36.
- R7: `alu_op` = 4 writes `y_q`, sign-extended from bit 31 to 36 bits, into accumulator `acc_dst`. The `align` setting has no effect on this move.
- R8: When `mul_en` is high together with `alu_op` 1, 2 or 3, the accumulate unit uses the `p_q` from before the edge. The new product appears in `p_q` at the same edge.
- R9: The aligned `p_q` is `p_q` sign-extended from bit 31 to 36 bits and then shifted according to `align`: 0 = no shift, 1 = arithmetic right shift by 2, 2 = left shift by 2, 3 = left shift by 1. The result is truncated to 36 bits.
- R10: With `square_mode` high and `y_load` high, `x_q` takes `y_data[31:16]` at the edge. This overrides any `x_load` in the same cycle.
- R11: With `square_mode` low, `x_load` loads `x_data` into `x_q` and `y_load` loads `y_data` into `y_q`. Registers that are not loaded hold their values.
- R12: `acc_src` and `acc_dst` may name the same accumulator. An operation never changes the accumulator that `acc_dst` does not select, and `alu_op` values 0, 5, 6 and 7 change neither accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously upstream |
| alu_op | input | 3 | Accumulate operation: 0 none, 1 move p, 2 add p, 3 subtract p, 4 move y |
| mul_en | input | 1 | Write x * y[31:16] into p at this edge |
| acc_src | input | 1 | Source accumulator index |
| acc_dst | input | 1 | Destination accumulator index |
| align | input | 2 | Product alignment setting |
| square_mode | input | 1 | Copy the upper half of each y load into x |
| x_load | input | 1 | Load x_data into x |
| x_data | input | 16 | Data for x |
| y_load | input | 1 | Load y_data into y |
| y_data | input | 32 | Data for y |
| x_q | output | 16 | x register |
| y_q | output | 32 | y register |
| p_q | output | 32 | Product register |
| acc0_q | output | 36 | Accumulator 0 |
| acc1_q | output | 36 | Accumulator 1 |

## Verification
The hardest situation to reach is a cycle that does several things at once. In it, a multiply overwrites `p` while the accumulate unit reads the old `p` through a non-zero alignment, and the source and destination accumulator are the same register. A wrong choice of product or a wrong operand order only shows up when consecutive products differ and the accumulators hold values that are neither zero nor symmetric. The stimulus therefore builds up distinct products and non-trivial accumulator contents first. It then issues back-to-back paired operations and sweeps all four alignments. It ends with a long run of mixed random operations, checked against a behavioural model on every clock. A chain of shifted additions drives an accumulator past 2^35 to exercise the wrap.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [2:0] {
    ALU_NONE = 3'd0,
    ALU_MOVP = 3'd1,
    ALU_ADDP = 3'd2,
    ALU_SUBP = 3'd3,
    ALU_MOVY = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    ALN_NONE = 2'd0,
    ALN_SR2  = 2'd1,
    ALN_SL2  = 2'd2,
    ALN_SL1  = 2'd3
  } align_e;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int X_W = 16
) (
  input  logic [X_W-1:0]   mcand,
  input  logic [X_W-1:0]   mplier,
  output logic [2*X_W-1:0] prod
);
  logic signed [2*X_W-1:0] prod_s;

  always_comb begin
    prod_s = $signed(mcand) * $signed(mplier);
    prod   = prod_s;
  end
endmodule

// File: rtl/fmac_align.sv
module fmac_align
  import fmac_pkg::*;
#(
  parameter int P_W   = 32,
  parameter int GUARD = 4
) (
  input  logic [P_W-1:0]       prod,
  input  logic [1:0]           mode,
  output logic [P_W+GUARD-1:0] aligned
);
  localparam int ACC_W = P_W + GUARD;

  logic signed [ACC_W-1:0] wide;

  always_comb begin
    wide = {{GUARD{prod[P_W-1]}}, prod};
    case (align_e'(mode))
      ALN_SR2: aligned = wide >>> 2;
      ALN_SL2: aligned = wide << 2;
      ALN_SL1: aligned = wide << 1;
      default: aligned = wide;
    endcase
  end
endmodule

// File: rtl/fmac_alu.sv
module fmac_alu
  import fmac_pkg::*;
#(
  parameter int ACC_W = 36
) (
  input  logic [2:0]       op,
  input  logic [ACC_W-1:0] src_acc,
  input  logic [ACC_W-1:0] p_term,
  input  logic [ACC_W-1:0] y_term,
  output logic [ACC_W-1:0] result,
  output logic             wr_en
);
  always_comb begin
    result = src_acc;
    wr_en  = 1'b1;
    case (alu_op_e'(op))
      ALU_MOVP: result = p_term;
      ALU_ADDP: result = src_acc + p_term;
      ALU_SUBP: result = src_acc - p_term;
      ALU_MOVY: result = y_term;
      default:  wr_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/fmac_datapath.sv
module fmac_datapath
  import fmac_pkg::*;
#(
  parameter int X_W     = 16,
  parameter int GUARD   = 4,
  parameter int NUM_ACC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             alu_op,
  input  logic                   mul_en,
  input  logic                   acc_src,
  input  logic                   acc_dst,
  input  logic [1:0]             align,
  input  logic                   square_mode,
  input  logic                   x_load,
  input  logic [X_W-1:0]         x_data,
  input  logic                   y_load,
  input  logic [2*X_W-1:0]       y_data,
  output logic [X_W-1:0]         x_q,
  output logic [2*X_W-1:0]       y_q,
  output logic [2*X_W-1:0]       p_q,
  output logic [2*X_W+GUARD-1:0] acc0_q,
  output logic [2*X_W+GUARD-1:0] acc1_q
);
  localparam int Y_W   = 2 * X_W;
  localparam int P_W   = Y_W;
  localparam int ACC_W = P_W + GUARD;

  logic [X_W-1:0]   x_d;
  logic             x_en;
  logic [P_W-1:0]   prod;
  logic [ACC_W-1:0] p_aligned;
  logic [ACC_W-1:0] y_wide;
  logic [ACC_W-1:0] alu_res;
  logic             alu_wr;
  logic [ACC_W-1:0] acc_q [NUM_ACC];

  // operand register next-state
  always_comb begin
    x_en = x_load | (y_load & square_mode);
    x_d  = (y_load & square_mode) ? y_data[Y_W-1:X_W] : x_data;
  end

  assign y_wide = {{GUARD{y_q[Y_W-1]}}, y_q};

  fmac_mult #(.X_W(X_W)) u_mult (
    .mcand  (x_q),
    .mplier (y_q[Y_W-1:X_W]),
    .prod   (prod)
  );

  fmac_align #(.P_W(P_W), .GUARD(GUARD)) u_align (
    .prod    (p_q),
    .mode    (align),
    .aligned (p_aligned)
  );

  fmac_alu #(.ACC_W(ACC_W)) u_alu (
    .op      (alu_op),
    .src_acc (acc_q[acc_src]),
    .p_term  (p_aligned),
    .y_term  (y_wide),
    .result  (alu_res),
    .wr_en   (alu_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    x_q <= '0;
    else if (x_en) x_q <= x_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_q <= '0;
    else if (y_load) y_q <= y_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      p_q <= '0;
    else if (mul_en) p_q <= prod;
  end

  generate
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
      logic acc_en;
      assign acc_en = alu_wr && (int'(acc_dst) == g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q[g] <= '0;
        else if (acc_en) acc_q[g] <= alu_res;
      end
    end
  endgenerate

  assign acc0_q = acc_q[0];
  assign acc1_q = acc_q[1];
endmodule

// File: rtl/fmac_checker.sv
module fmac_checker #(
  parameter int X_W   = 16,
  parameter int GUARD = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             alu_op,
  input logic                   mul_en,
  input logic                   acc_dst,
  input logic                   square_mode,
  input logic                   y_load,
  input logic [2*X_W-1:0]       y_data,
  input logic [X_W-1:0]         x_q,
  input logic [2*X_W-1:0]       y_q,
  input logic [2*X_W-1:0]       p_q,
  input logic [2*X_W+GUARD-1:0] acc0_q,
  input logic [2*X_W+GUARD-1:0] acc1_q
);
  localparam int Y_W = 2 * X_W;

  AST_SQUARE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (y_load && square_mode) |=> (x_q == $past(y_data[Y_W-1:X_W]))); // R10

  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |=> (p_q == Y_W'($signed($past(x_q)) * $signed($past(y_q[Y_W-1:X_W]))))); // R2

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_en |=> $stable(p_q)); // R2

  AST_MUL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd0) |=> ($stable(acc0_q) && $stable(acc1_q))); // R3

  AST_OTHER_ACC0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dst == 1'b1) |=> $stable(acc0_q)); // R12

  AST_OTHER_ACC1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dst == 1'b0) |=> $stable(acc1_q)); // R12

  AST_MOVE_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd4 && acc_dst == 1'b0) |=>
      (acc0_q == {{GUARD{$past(y_q[Y_W-1])}}, $past(y_q)})); // R7
endmodule

bind fmac_datapath fmac_checker #(.X_W(X_W), .GUARD(GUARD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_op      (alu_op),
  .mul_en      (mul_en),
  .acc_dst     (acc_dst),
  .square_mode (square_mode),
  .y_load      (y_load),
  .y_data      (y_data),
  .x_q         (x_q),
  .y_q         (y_q),
  .p_q         (p_q),
  .acc0_q      (acc0_q),
  .acc1_q      (acc1_q)
);

// File: tb/fmac_datapath_tb.sv
module fmac_datapath_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  alu_op = '0;
  logic        mul_en = 1'b0;
  logic        acc_src = 1'b0;
  logic        acc_dst = 1'b0;
  logic [1:0]  align = '0;
  logic        square_mode = 1'b0;
  logic        x_load = 1'b0;
  logic [15:0] x_data = '0;
  logic        y_load = 1'b0;
  logic [31:0] y_data = '0;
  logic [15:0] x_q;
  logic [31:0] y_q;
  logic [31:0] p_q;
  logic [35:0] acc0_q;
  logic [35:0] acc1_q;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  logic [15:0] mx;
  logic [31:0] my;
  logic [31:0] mp;
  logic [35:0] macc [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmac_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .mul_en(mul_en),
    .acc_src(acc_src), .acc_dst(acc_dst), .align(align),
    .square_mode(square_mode), .x_load(x_load), .x_data(x_data),
    .y_load(y_load), .y_data(y_data), .x_q(x_q), .y_q(y_q), .p_q(p_q),
    .acc0_q(acc0_q), .acc1_q(acc1_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "x", {20'd0, x_q}, {20'd0, mx});
    check(tag, "y", {4'd0, y_q}, {4'd0, my});
    check(tag, "p", {4'd0, p_q}, {4'd0, mp});
    check(tag, "acc0", acc0_q, macc[0]);
    check(tag, "acc1", acc1_q, macc[1]);
  endtask

  function automatic logic [35:0] scale_p(input logic [31:0] p, input logic [1:0] al);
    longint v;
    v = longint'($signed(p));
    case (al)
      2'd1: v = v / 4 - ((v < 0 && (v % 4) != 0) ? 1 : 0);
      2'd2: v = v * 4;
      2'd3: v = v * 2;
      default: ;
    endcase
    return v[35:0];
  endfunction

  // one clock: drive at a falling edge, predict, compare at the next falling edge
  task automatic step(input string tag, input logic [2:0] op, input logic mul,
                      input logic src, input logic dst, input logic [1:0] al,
                      input logic sq, input logic xl, input logic [15:0] xd,
                      input logic yl, input logic [31:0] yd);
    logic [15:0] nx;
    logic [31:0] ny, np;
    logic [35:0] nacc [2];
    longint prod;
    alu_op = op; mul_en = mul; acc_src = src; acc_dst = dst; align = al;
    square_mode = sq; x_load = xl; x_data = xd; y_load = yl; y_data = yd;
    nx = mx; ny = my; np = mp; nacc[0] = macc[0]; nacc[1] = macc[1];
    if (yl && sq) nx = yd[31:16];
    else if (xl)  nx = xd;
    if (yl) ny = yd;
    if (mul) begin
      prod = longint'($signed(mx)) * longint'($signed(my[31:16]));
      np = prod[31:0];
    end
    case (op)
      3'd1: nacc[dst] = scale_p(mp, al);
      3'd2: nacc[dst] = macc[src] + scale_p(mp, al);
      3'd3: nacc[dst] = macc[src] - scale_p(mp, al);
      3'd4: nacc[dst] = {{4{my[31]}}, my};
      default: ;
    endcase
    @(negedge clk);
    mx = nx; my = ny; mp = np; macc[0] = nacc[0]; macc[1] = nacc[1];
    compare_all(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    mx = '0; my = '0; mp = '0; macc[0] = '0; macc[1] = '0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;

    // R11: plain loads, lower half of y differs from zero
    step("R11", 3'd0, 0, 0, 0, 2'd0, 0, 1, 16'd3, 1, 32'h0005_ABCD);
    step("R11", 3'd0, 0, 0, 0, 2'd0, 0, 0, 16'h7777, 0, 32'h1111_1111);
    // R2: product ignores y[15:0]
    step("R2", 3'd0, 1, 0, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    step("R2", 3'd0, 0, 0, 0, 2'd0, 0, 1, 16'hFFF9, 1, 32'h1234_FFFF);
    step("R2", 3'd0, 1, 0, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    // R4: move p unaligned, R9: each alignment into acc1
    step("R4", 3'd1, 0, 0, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    step("R9", 3'd1, 0, 0, 1, 2'd1, 0, 0, 16'd0, 0, 32'd0);
    step("R9", 3'd1, 0, 0, 1, 2'd2, 0, 0, 16'd0, 0, 32'd0);
    step("R9", 3'd1, 0, 0, 1, 2'd3, 0, 0, 16'd0, 0, 32'd0);
    // R5 / R6 across accumulators, R12 same source and destination
    step("R5", 3'd2, 0, 1, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    step("R6", 3'd3, 0, 0, 1, 2'd2, 0, 0, 16'd0, 0, 32'd0);
    step("R12", 3'd3, 0, 1, 1, 2'd1, 0, 0, 16'd0, 0, 32'd0);
    step("R12", 3'd6, 1, 0, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    // R7: negative y, alignment set but not applied
    step("R7", 3'd0, 0, 0, 0, 2'd2, 0, 0, 16'd0, 1, 32'h8000_0001);
    step("R7", 3'd4, 0, 0, 1, 2'd2, 0, 0, 16'd0, 0, 32'd0);
    // R3: multiply only
    step("R3", 3'd0, 1, 1, 1, 2'd3, 0, 1, 16'h0101, 0, 32'd0);
    step("R3", 3'd0, 1, 0, 0, 2'd1, 0, 0, 16'd0, 1, 32'h0202_0000);
    // R8: back-to-back paired operations with changing products
    step("R8", 3'd2, 1, 0, 0, 2'd0, 0, 1, 16'h0011, 0, 32'd0);
    step("R8", 3'd3, 1, 0, 1, 2'd2, 0, 0, 16'd0, 1, 32'hFF00_0000);
    step("R8", 3'd1, 1, 1, 0, 2'd1, 0, 0, 16'd0, 0, 32'd0);
    // R5: wrap modulo 2^36
    step("R5", 3'd0, 0, 0, 0, 2'd0, 0, 1, 16'h7FFF, 1, 32'h7FFF_0000);
    step("R5", 3'd4, 1, 0, 0, 2'd0, 0, 0, 16'd0, 0, 32'd0);
    for (int i = 0; i < 40; i++)
      step("R5", 3'd2, 0, 0, 0, 2'd2, 0, 0, 16'd0, 0, 32'd0);
    // R10: squaring mode overrides x_load
    step("R10", 3'd0, 0, 0, 0, 2'd0, 1, 1, 16'h1234, 1, 32'hFF85_1111);
    step("R10", 3'd0, 1, 0, 0, 2'd0, 1, 0, 16'd0, 0, 32'd0);
    step("R10", 3'd1, 0, 0, 1, 2'd0, 1, 0, 16'd0, 0, 32'd0);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step("R12", 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom), 1'($urandom), $urandom);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule